// File: doc/BRIEF.md
# Log-Domain Gain Error Generator

This block sits in a digital gain-control loop, between the decimating power filter and the loop integrator. It takes an unsigned power magnitude and compresses it into a short floating-point code. The code has a three-bit exponent taken from the position of the most significant set bit and a two-bit mantissa taken from the bits just below it. The code is the address into a host-loaded table of signed bytes.

The host fills the table with a curve of its choosing. In practice the curve folds together a logarithm, subtraction of the servo reference, a zero-valued deadband around that reference, and an error slope. The deadband must be wider than the gain step of the downstream amplifier, so that the loop does not hunt between two steps. The table word is sign-extended to the integrator width. It is then multiplied by a power of two chosen by a small gain register, with saturation at the signed rails. The result leaves on a registered output with a valid strobe.

Top module: `log_agc_error`

## Requirements
- R1: After reset, err_valid and err are 0, every table word is 0 and the gain register is 0.
- R2: A magnitude below 4 yields code {3'b000, mag[1:0]}.
- R3: A magnitude of 4 or more whose highest set bit is p (2..8) yields exponent p-1 in code bits [4:2], and mantissa mag[p-1:p-2] in code bits [1:0].
- R4: With host_we=1 and host_sel=0, host_wdata is written to the table word at host_addr. The word addressed by the code is what feeds the output.
- R5: With host_we=1 and host_sel=1, host_wdata[1:0] is written to the gain register g. The output is the sign-extended table word multiplied by 2^(g+1).
- R6: A scaled value above 1023 gives 1023, and a scaled value below -1024 gives -1024.
- R7: err_valid rises exactly two clock edges after the edge that samples mag_valid=1, and is low otherwise. err holds its value between valid results.
- R8: A table write committed at an edge is seen by any lookup that completes at a later edge. A lookup that completes at the same edge sees the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mag_valid | input | 1 | Magnitude strobe |
| mag | input | 9 | Unsigned power magnitude |
| host_we | input | 1 | Host write enable |
| host_sel | input | 1 | 0 = table word, 1 = gain register |
| host_addr | input | 5 | Table word index |
| host_wdata | input | 8 | Host write data |
| err_valid | output | 1 | Error strobe |
| err | output | 11 | Signed scaled gain error |

## Verification
The assertions assume that mag_valid and the host write lines are clean after reset. They also assume that a host write can land in any cycle, including the cycle in which its own address is being looked up. The stimulus drives every input on the falling edge. It places writes both clear of lookups and deliberately on top of an in-flight lookup to the same word. The saturation checks use table words at both extremes of the signed byte range, with the largest gain.

// File: rtl/agc_err_pkg.sv
package agc_err_pkg;
    localparam int MAG_W  = 9;
    localparam int EXP_W  = 3;
    localparam int MAN_W  = 2;
    localparam int CODE_W = EXP_W + MAN_W;
    localparam int DEPTH  = 1 << CODE_W;
    localparam int WORD_W = 8;
    localparam int GAIN_W = 2;
    localparam int OUT_W  = 11;

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] code;
    } enc_st_t;

    typedef struct packed {
        logic                          vld;
        logic signed [OUT_W-1:0]       val;
    } out_st_t;
endpackage

// File: rtl/agc_float_enc.sv
module agc_float_enc
    import agc_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [MAG_W-1:0]  in_mag,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code
);
    enc_st_t st_d, st_q;

    always_comb begin
        int lead;
        logic found;
        lead  = 0;
        found = 1'b0;
        for (int i = MAN_W; i < MAG_W; i++) begin
            if (in_mag[i]) begin
                lead  = i;
                found = 1'b1;
            end
        end
        st_d = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (found)
                st_d.code = {EXP_W'(lead - MAN_W + 1), MAN_W'(in_mag >> (lead - MAN_W))};
            else
                st_d.code = {{EXP_W{1'b0}}, in_mag[MAN_W-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_code  = st_q.code;

    // Small magnitudes map to a zero exponent
    assert_small_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ((in_mag >> MAN_W) == 0) |=> out_code == CODE_W'($past(in_mag)));

    // Nonzero exponent e means the highest set bit is e+MAN_W-1
    assert_lead_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ((in_mag >> MAN_W) != 0) |=>
            (($past(in_mag) >> (int'(out_code[CODE_W-1:MAN_W]) + MAN_W - 1)) == 1));
endmodule

// File: rtl/agc_lut.sv
module agc_lut
    import agc_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CODE_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [CODE_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word,
    output logic [GAIN_W-1:0] gain
);
    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] words;
        logic [GAIN_W-1:0]            gain;
    } lut_st_t;

    lut_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_sel) st_d.words[wr_addr] = wr_data;
        if (wr_en &&  wr_sel) st_d.gain = wr_data[GAIN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_word = st_q.words[rd_addr];
    assign gain    = st_q.gain;

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_sel |=> st_q.words[$past(wr_addr)] == $past(wr_data));

    assert_gain_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel |=> gain == $past(wr_data[GAIN_W-1:0]));
endmodule

// File: rtl/agc_scale_sat.sv
module agc_scale_sat
    import agc_err_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [WORD_W-1:0]       in_word,
    input  logic [GAIN_W-1:0]       in_gain,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_val
);
    localparam int MAX_SH = (1 << GAIN_W);
    localparam int WIDE_W = WORD_W + MAX_SH + 1;
    localparam logic signed [WIDE_W-1:0] POS_RAIL = WIDE_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [WIDE_W-1:0] NEG_RAIL = -WIDE_W'(1 << (OUT_W - 1));

    out_st_t st_d, st_q;

    always_comb begin
        logic signed [WIDE_W-1:0] ext;
        logic signed [WIDE_W-1:0] scaled;
        ext    = WIDE_W'($signed(in_word));
        scaled = ext <<< (int'(in_gain) + 1);
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (scaled > POS_RAIL)      st_d.val = POS_RAIL[OUT_W-1:0];
            else if (scaled < NEG_RAIL) st_d.val = NEG_RAIL[OUT_W-1:0];
            else                        st_d.val = scaled[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_val   = st_q.val;

    // Zero word stays zero, sign of a nonzero word is kept
    assert_zero_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_val == 0) == ($past(in_word) == 0)));

    assert_sign_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_val[OUT_W-1] == $past(in_word[WORD_W-1])));

    // Off the rails the result is an even multiple
    assert_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_val != POS_RAIL[OUT_W-1:0]) |-> !out_val[0]);
endmodule

// File: rtl/log_agc_error.sv
module log_agc_error
    import agc_err_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mag_valid,
    input  logic [8:0]  mag,
    input  logic        host_we,
    input  logic        host_sel,
    input  logic [4:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic        err_valid,
    output logic [10:0] err
);
    logic              enc_vld;
    logic [CODE_W-1:0] enc_code;
    logic [WORD_W-1:0] lut_word;
    logic [GAIN_W-1:0] lut_gain;
    logic signed [OUT_W-1:0] sc_val;

    agc_float_enc u_enc (
        .clk(clk), .rst_n(rst_n),
        .in_valid(mag_valid), .in_mag(mag),
        .out_valid(enc_vld), .out_code(enc_code)
    );

    agc_lut u_lut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_we), .wr_sel(host_sel),
        .wr_addr(host_addr), .wr_data(host_wdata),
        .rd_addr(enc_code), .rd_word(lut_word), .gain(lut_gain)
    );

    agc_scale_sat u_sc (
        .clk(clk), .rst_n(rst_n),
        .in_valid(enc_vld), .in_word(lut_word), .in_gain(lut_gain),
        .out_valid(err_valid), .out_val(sc_val)
    );

    assign err = sc_val;

    assert_latency_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mag_valid |-> ##2 err_valid);

    assert_latency_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mag_valid |-> ##2 !err_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> $stable(err));
endmodule

// File: tb/log_agc_error_test.sv
module log_agc_error_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mag_valid = 1'b0;
    logic [8:0]  mag = '0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        err_valid;
    logic [10:0] err;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [7:0] tbl [32];
    int gain_m = 0;

    always #4 clk = ~clk;

    log_agc_error uut (
        .clk(clk), .rst_n(rst_n), .mag_valid(mag_valid), .mag(mag),
        .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
        .host_wdata(host_wdata), .err_valid(err_valid), .err(err)
    );

    function automatic int code_of(int m);
        int p;
        if (m < 4) return m;
        p = 2;
        for (int i = 2; i < 9; i++) if (((m >> i) & 1) == 1) p = i;
        return ((p - 1) << 2) | ((m >> (p - 2)) & 3);
    endfunction

    function automatic int model(int m);
        int w, v;
        w = int'($signed(tbl[code_of(m)]));
        v = w * (1 << (gain_m + 1));
        if (v > 1023) v = 1023;
        if (v < -1024) v = -1024;
        return v;
    endfunction

    task automatic check(string req, int actual, int expected);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic host_write(bit sel, int addr, int data);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_addr = 5'(addr); host_wdata = 8'(data);
        @(negedge clk);
        host_we = 1'b0;
        if (sel) gain_m = data & 3; else tbl[addr] = 8'(data);
    endtask

    task automatic lookup(string req, int m);
        @(negedge clk);
        mag_valid = 1'b1; mag = 9'(m);
        @(negedge clk);
        mag_valid = 1'b0;
        @(posedge clk); #1;
        check({req, " valid"}, int'(err_valid), 1);
        check(req, int'($signed(err)), model(m));
    endtask

    task automatic t_reset();
        check("R1 err_valid", int'(err_valid), 0);
        check("R1 err", int'(err), 0);
        lookup("R1 zero table", 300);
        lookup("R1 zero table small", 2);
    endtask

    task automatic t_codes();
        // unique entry per address: entry = 3*addr - 40
        for (int a = 0; a < 32; a++) host_write(1'b0, a, 3 * a - 40);
        for (int m = 0; m < 4; m++) lookup("R2 small code", m);
        lookup("R3 lead bit2", 4);
        lookup("R3 lead bit2", 7);
        lookup("R3 lead bit3", 13);
        lookup("R3 lead bit5", 45);
        lookup("R3 lead bit7", 200);
        lookup("R3 lead bit8", 256);
        lookup("R3 top", 511);
        lookup("R3 mid", 383);
        lookup("R4 table", 100);
    endtask

    task automatic t_gain();
        for (int g = 0; g < 4; g++) begin
            host_write(1'b1, 0, g);
            lookup("R5 gain", 96);
            lookup("R5 gain neg", 5);
        end
        host_write(1'b0, code_of(60), 0);
        lookup("R5 deadband zero", 60);
    endtask

    task automatic t_sat();
        host_write(1'b1, 0, 3);
        host_write(1'b0, code_of(300), 127);
        lookup("R6 pos rail", 300);
        check("R6 pos value", int'($signed(err)), 1023);
        host_write(1'b0, code_of(300), -128);
        lookup("R6 neg rail", 300);
        check("R6 neg value", int'($signed(err)), -1024);
        host_write(1'b0, code_of(300), 63);
        lookup("R6 under rail", 300);
        host_write(1'b1, 0, 0);
        host_write(1'b0, code_of(300), -128);
        lookup("R6 no sat", 300);
    endtask

    task automatic t_latency();
        int held;
        held = int'($signed(err));
        @(negedge clk);
        mag_valid = 1'b1; mag = 9'd20;
        @(posedge clk); #1;
        check("R7 one edge", int'(err_valid), 0);
        check("R7 hold", int'($signed(err)), held);
        @(negedge clk);
        mag_valid = 1'b0;
        @(posedge clk); #1;
        check("R7 two edges", int'(err_valid), 1);
        check("R7 value", int'($signed(err)), model(20));
        held = int'($signed(err));
        @(posedge clk); #1;
        check("R7 drops", int'(err_valid), 0);
        check("R7 hold after", int'($signed(err)), held);
    endtask

    task automatic t_collide();
        int old_v, c;
        host_write(1'b1, 0, 1);
        c = code_of(150);
        host_write(1'b0, c, 10);
        old_v = model(150);
        @(negedge clk);
        mag_valid = 1'b1; mag = 9'd150;
        @(negedge clk);
        mag_valid = 1'b0;
        host_we = 1'b1; host_sel = 1'b0; host_addr = 5'(c); host_wdata = 8'd50;
        @(posedge clk); #1;
        check("R8 same edge old", int'($signed(err)), old_v);
        @(negedge clk);
        host_we = 1'b0;
        tbl[c] = 8'd50;
        lookup("R8 next lookup new", 150);
        check("R8 new value", int'($signed(err)), 200);
    endtask

    initial begin
        for (int a = 0; a < 32; a++) tbl[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_codes();
        t_gain();
        t_sat();
        t_latency();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule